// File: doc/BRIEF.md
# Receive Ring Pointer Manager

This block keeps track of where incoming frames are placed in a circular receive area of word-wide external memory. It owns four pointer registers (ring start, ring end, hardware write pointer and software read pointer), each holding an 18-bit word offset. All four share one 12-bit upper address field, and that field is kept only in the start register. From these pointers the block derives two status outputs: whether the ring is empty, and whether the space ahead of the write pointer is too small for a frame of the largest size.

A frame source raises a start pulse when a frame begins. It later raises a done pulse together with the frame length in words. When an accepted frame completes, the write pointer moves past the frame and one header word. The block then checks how much room is left before the ring end. If the room is too small, it writes a zero marker word through a simple request/acknowledge port and returns the write pointer to the ring start. A frame that begins while room is short, or while the block is still busy, is dropped and an overflow flag is raised.

Top module: `rxring_ptr_mgr`

## Requirements
- R1: Register select codes are 0 = start, 1 = end, 2 = write pointer, 3 = read pointer. The start register reads back as {base[31:20], offset[19:2], 2'b00}. Written bits 1..0 are ignored.
- R2: The end, write-pointer and read-pointer registers read back the start register's base in bits 31..20. Bits 31..20 written to them are ignored. Only their bits 19..2 are stored.
- R3: When an accepted frame finishes (done pulse with length L), the write pointer becomes the old write pointer + L + 1, modulo 2^18.
- R4: In the cycle after that advance, the block checks the room before the ring end. If end < write pointer, or end − write pointer < MAX_FRAME_WORDS, it raises mem_req with mem_addr = {base, write pointer, 2'b00} and mem_wdata = 0, and holds both until mem_ack.
- R5: On the clock edge where mem_req and mem_ack are both high, the write pointer is loaded with the ring start offset.
- R6: lack_of_space is high exactly when read pointer > write pointer and read pointer − write pointer < MAX_FRAME_WORDS.
- R7: buf_empty is high exactly when the write pointer equals the read pointer.
- R8: A start pulse that arrives while lack_of_space or busy is high is dropped. The overflow flag is set on the next edge, and the write pointer is not moved by that start or by any done pulse that follows it.
- R9: ovf_clr clears the overflow flag on the next edge. A drop in the same cycle takes priority and keeps the flag set.
- R10: busy rises on the edge after an accepted start. It stays high through the frame, the room check and any marker write, and falls on the edge that finishes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 2 | Register select (0 start, 1 end, 2 write ptr, 3 read ptr) |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Read data of the selected register |
| frm_start | input | 1 | Frame begins (pulse) |
| frm_done | input | 1 | Frame complete (pulse) |
| frm_len | input | LEN_W | Frame length in words, valid with frm_done |
| ovf_clr | input | 1 | Clears the overflow flag |
| mem_req | output | 1 | Marker word write request |
| mem_addr | output | 32 | Byte address of the marker word |
| mem_wdata | output | 32 | Marker data (zero) |
| mem_ack | input | 1 | Memory accepted the write |
| lack_of_space | output | 1 | Read pointer too close ahead of write pointer |
| buf_empty | output | 1 | Write pointer equals read pointer |
| busy | output | 1 | Frame in progress or wrap handling |
| ovf_flag | output | 1 | A frame was dropped |

## Verification
The bench builds the block with MAX_FRAME_WORDS set to 8 instead of 380. With that value, a ring of a few dozen words is enough to reach the wrap marker after three frames, to bring the read pointer within one frame of the write pointer, and to exercise the exact threshold cases of both comparisons. A delayed acknowledge keeps the marker request held for several cycles, and dropped starts are issued both under lack of space and while a frame is still open.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
    localparam int OFF_W  = 18;
    localparam int BASE_W = 12;
    localparam int DATA_W = 32;

    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [BASE_W-1:0] base_t;

    typedef enum logic [1:0] {
        SEL_START = 2'd0,
        SEL_END   = 2'd1,
        SEL_WPTR  = 2'd2,
        SEL_RPTR  = 2'd3
    } reg_sel_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FRAME = 2'd1,
        ST_CHECK = 2'd2,
        ST_WRAP  = 2'd3
    } ctrl_state_t;

    typedef struct packed {
        base_t base;
        off_t  start;
        off_t  stop;
        off_t  wptr;
        off_t  rptr;
    } ring_ptrs_t;

    function automatic logic [DATA_W-1:0] word_addr(base_t b, off_t o);
        return {b, o, 2'b00};
    endfunction
endpackage

// File: rtl/rxring_regs.sv
module rxring_regs
    import rxring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              hw_load,
    input  off_t              hw_val,
    output ring_ptrs_t        ptrs,
    output logic [DATA_W-1:0] rdata
);
    localparam int OFF_LSB = 2;
    localparam int OFF_MSB = OFF_LSB + OFF_W - 1;
    localparam int BASE_LSB = OFF_MSB + 1;

    ring_ptrs_t q;
    off_t wr_off;
    reg_sel_t sel;

    assign wr_off = reg_wdata[OFF_MSB:OFF_LSB];
    assign sel    = reg_sel_t'(reg_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            if (reg_wr) begin
                case (sel)
                    SEL_START: begin
                        q.base  <= reg_wdata[DATA_W-1:BASE_LSB];
                        q.start <= wr_off;
                    end
                    SEL_END:  q.stop <= wr_off;
                    SEL_RPTR: q.rptr <= wr_off;
                    default:  if (!hw_load) q.wptr <= wr_off;
                endcase
            end
            if (hw_load) q.wptr <= hw_val;
        end
    end

    always_comb begin
        case (sel)
            SEL_START: rdata = word_addr(q.base, q.start);
            SEL_END:   rdata = word_addr(q.base, q.stop);
            SEL_WPTR:  rdata = word_addr(q.base, q.wptr);
            default:   rdata = word_addr(q.base, q.rptr);
        endcase
    end

    assign ptrs = q;
endmodule

// File: rtl/rxring_space.sv
module rxring_space
    import rxring_pkg::*;
#(
    parameter int MAX_FRAME_WORDS = 380
) (
    input  ring_ptrs_t ptrs,
    output logic       los,
    output logic       empty,
    output logic       room_short
);
    localparam logic [OFF_W:0] MAXW = (OFF_W+1)'(MAX_FRAME_WORDS);

    logic [OFF_W:0] gap_read;
    logic [OFF_W:0] gap_end;

    always_comb begin
        gap_read   = {1'b0, ptrs.rptr} - {1'b0, ptrs.wptr};
        gap_end    = {1'b0, ptrs.stop} - {1'b0, ptrs.wptr};
        los        = (ptrs.rptr > ptrs.wptr) && (gap_read < MAXW);
        empty      = (ptrs.rptr == ptrs.wptr);
        room_short = (ptrs.stop < ptrs.wptr) || (gap_end < MAXW);
    end
endmodule

// File: rtl/rxring_ctrl.sv
module rxring_ctrl
    import rxring_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_start,
    input  logic              frm_done,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              ovf_clr,
    input  logic              los,
    input  logic              room_short,
    input  ring_ptrs_t        ptrs,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic [DATA_W-1:0] mem_addr,
    output logic              hw_load,
    output off_t              hw_val,
    output logic              busy,
    output logic              ovf_flag
);
    ctrl_state_t state, state_n;
    logic accept, drop;

    assign accept = frm_start && (state == ST_IDLE) && !los;
    assign drop   = frm_start && !accept;

    always_comb begin
        state_n = state;
        hw_load = 1'b0;
        hw_val  = ptrs.wptr;
        case (state)
            ST_IDLE:  if (accept) state_n = ST_FRAME;
            ST_FRAME: if (frm_done) begin
                hw_load = 1'b1;
                hw_val  = ptrs.wptr + off_t'(frm_len) + off_t'(1);
                state_n = ST_CHECK;
            end
            ST_CHECK: state_n = room_short ? ST_WRAP : ST_IDLE;
            default:  if (mem_ack) begin
                hw_load = 1'b1;
                hw_val  = ptrs.start;
                state_n = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ovf_flag <= 1'b0;
        end else begin
            state <= state_n;
            if (drop)         ovf_flag <= 1'b1;
            else if (ovf_clr) ovf_flag <= 1'b0;
        end
    end

    assign busy     = (state != ST_IDLE);
    assign mem_req  = (state == ST_WRAP);
    assign mem_addr = word_addr(ptrs.base, ptrs.wptr);
endmodule

// File: rtl/rxring_ptr_mgr.sv
module rxring_ptr_mgr
    import rxring_pkg::*;
#(
    parameter int MAX_FRAME_WORDS = 380,
    parameter int LEN_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              frm_start,
    input  logic              frm_done,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic              ovf_clr,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    output logic              lack_of_space,
    output logic              buf_empty,
    output logic              busy,
    output logic              ovf_flag
);
    ring_ptrs_t ptrs;
    logic       hw_load;
    off_t       hw_val;
    logic       room_short;
    off_t       wptr_off;
    off_t       start_off;

    rxring_regs u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .hw_load(hw_load), .hw_val(hw_val),
        .ptrs(ptrs), .rdata(reg_rdata)
    );

    rxring_space #(.MAX_FRAME_WORDS(MAX_FRAME_WORDS)) u_space (
        .ptrs(ptrs), .los(lack_of_space), .empty(buf_empty),
        .room_short(room_short)
    );

    rxring_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst(rst), .frm_start(frm_start), .frm_done(frm_done),
        .frm_len(frm_len), .ovf_clr(ovf_clr), .los(lack_of_space),
        .room_short(room_short), .ptrs(ptrs), .mem_ack(mem_ack),
        .mem_req(mem_req), .mem_addr(mem_addr), .hw_load(hw_load),
        .hw_val(hw_val), .busy(busy), .ovf_flag(ovf_flag)
    );

    assign mem_wdata = '0;
    assign wptr_off  = ptrs.wptr;
    assign start_off = ptrs.start;
endmodule

// File: rtl/rxring_chk.sv
module rxring_chk
    import rxring_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        frm_start,
    input logic        ovf_clr,
    input logic        lack_of_space,
    input logic        buf_empty,
    input logic        busy,
    input logic        ovf_flag,
    input logic        mem_req,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input off_t        wptr_off,
    input off_t        start_off
);
    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    // R5
    wrap_restart_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_ack |=> wptr_off == $past(start_off));

    // R6
    los_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
        lack_of_space |-> !buf_empty);

    // R8
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        frm_start && (lack_of_space || busy) |=> ovf_flag && $stable(wptr_off));

    // R9
    ovf_clear_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_clr && !(frm_start && (lack_of_space || busy)) |=> !ovf_flag);

    // R10
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        frm_start && !busy && !lack_of_space |=> busy);
endmodule

bind rxring_ptr_mgr rxring_chk u_chk (
    .clk(clk), .rst(rst), .frm_start(frm_start), .ovf_clr(ovf_clr),
    .lack_of_space(lack_of_space), .buf_empty(buf_empty), .busy(busy),
    .ovf_flag(ovf_flag), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .wptr_off(wptr_off), .start_off(start_off)
);

// File: tb/sim_rxring_ptr_mgr.sv
`timescale 1ns/1ps
module sim_rxring_ptr_mgr;
    localparam int MAXW  = 8;
    localparam int LEN_W = 12;
    localparam int MASK  = 32'h3FFFF;

    logic clk = 0, rst = 1;
    logic reg_wr = 0;
    logic [1:0] reg_sel = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic frm_start = 0, frm_done = 0, ovf_clr = 0, mem_ack = 0;
    logic [LEN_W-1:0] frm_len = 0;
    logic mem_req, lack_of_space, buf_empty, busy, ovf_flag;
    logic [31:0] mem_addr, mem_wdata;

    int checks = 0, fails = 0, cycles = 0;
    int m_base = 0, m_start = 0, m_end = 0, m_in = 0, m_out = 0, m_st = 0;
    bit m_ovf = 0;

    always #5 clk = ~clk;

    rxring_ptr_mgr #(.MAX_FRAME_WORDS(MAXW), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frm_start(frm_start),
        .frm_done(frm_done), .frm_len(frm_len), .ovf_clr(ovf_clr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .lack_of_space(lack_of_space), .buf_empty(buf_empty),
        .busy(busy), .ovf_flag(ovf_flag)
    );

    function automatic logic [31:0] mk(int off);
        return {m_base[11:0], off[17:0], 2'b00};
    endfunction

    function automatic bit m_los();
        return (m_out > m_in) && ((m_out - m_in) < MAXW);
    endfunction

    // Behavioural reference model, stepped on every clock edge
    always @(posedge clk) begin
        if (rst) begin
            m_base = 0; m_start = 0; m_end = 0; m_in = 0; m_out = 0;
            m_st = 0; m_ovf = 0;
        end else begin
            bit los_now, short_now, hw, acc;
            int nin;
            los_now   = m_los();
            short_now = (m_end < m_in) || ((m_end - m_in) < MAXW);
            acc = frm_start && m_st == 0 && !los_now;
            if (frm_start && !acc) m_ovf = 1;
            else if (ovf_clr) m_ovf = 0;
            hw = 0; nin = m_in;
            case (m_st)
                0: if (acc) m_st = 1;
                1: if (frm_done) begin hw = 1; nin = (m_in + int'(frm_len) + 1) & MASK; m_st = 2; end
                2: m_st = short_now ? 3 : 0;
                default: if (mem_ack) begin hw = 1; nin = m_start; m_st = 0; end
            endcase
            if (reg_wr) begin
                case (reg_sel)
                    2'd0: begin m_base = int'(reg_wdata[31:20]); m_start = int'(reg_wdata[19:2]); end
                    2'd1: m_end = int'(reg_wdata[19:2]);
                    2'd2: if (!hw) m_in = int'(reg_wdata[19:2]);
                    default: m_out = int'(reg_wdata[19:2]);
                endcase
            end
            if (hw) m_in = nin;
        end
    end

    task automatic check1(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
        end
    endtask

    // Compare every cycle, two time units after the edge
    always @(posedge clk) begin
        cycles++;
        #2;
        if (!rst) begin
            logic [31:0] er;
            case (reg_sel)
                2'd0: er = mk(m_start);
                2'd1: er = mk(m_end);
                2'd2: er = mk(m_in);
                default: er = mk(m_out);
            endcase
            case (reg_sel)
                2'd0: check1("R1 start readback", reg_rdata, er);
                2'd2: check1("R2 R3 R5 write pointer readback", reg_rdata, er);
                default: check1("R2 end/read pointer readback", reg_rdata, er);
            endcase
            check1("R6 lack_of_space", 32'(lack_of_space), 32'(m_los()));
            check1("R7 buf_empty", 32'(buf_empty), 32'(m_in == m_out));
            check1("R10 busy", 32'(busy), 32'(m_st != 0));
            check1("R8 R9 ovf_flag", 32'(ovf_flag), 32'(m_ovf));
            check1("R4 mem_req", 32'(mem_req), 32'(m_st == 3));
            if (m_st == 3) begin
                check1("R4 mem_addr", mem_addr, mk(m_in));
                check1("R4 mem_wdata", mem_wdata, 32'h0);
            end
        end
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog expired: actual running expected finished");
            finish_run();
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic wr(int sel, logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_sel = sel[1:0]; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic peek_all();
        for (int s = 0; s < 4; s++) begin
            @(negedge clk); reg_sel = s[1:0];
        end
        @(negedge clk);
    endtask

    task automatic service(int n);
        int w = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            mem_ack = 0;
            if (mem_req) begin
                w++;
                if (w == 3) begin mem_ack = 1; w = 0; end
            end
        end
        @(negedge clk); mem_ack = 0;
    endtask

    task automatic frame(int len);
        @(negedge clk); frm_start = 1;
        @(negedge clk); frm_start = 0;
        @(negedge clk);
        @(negedge clk); frm_done = 1; frm_len = len[LEN_W-1:0];
        @(negedge clk); frm_done = 0;
        service(8);
        peek_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        peek_all();                                   // reset state, R1 R7
        wr(0, {12'hABC, 18'h10, 2'b11});              // R1 low bits ignored
        wr(1, {12'hFFF, 18'h40, 2'b11});              // R2 upper bits ignored
        wr(2, {12'h123, 18'h10, 2'b00});
        wr(3, {12'h000, 18'h10, 2'b00});
        peek_all();
        frame(5);                                     // R3: 0x16
        frame(20);                                    // R3: 0x2B
        frame(14);                                    // R4 R5: 0x3A wraps to 0x10
        wr(3, {12'h0, 18'h2B, 2'b00});
        peek_all();
        frame(20);                                    // R6: gap 6 -> lack of space
        frame(3);                                     // R8: dropped
        @(negedge clk); ovf_clr = 1;                  // R9
        @(negedge clk); ovf_clr = 0;
        wr(3, {12'h0, 18'h2D, 2'b00});                // gap exactly 8: R6 low
        peek_all();
        wr(3, {12'h0, 18'h2C, 2'b00});                // gap 7: R6 high
        wr(3, {12'h0, 18'h25, 2'b00});                // R7 empty
        peek_all();
        @(negedge clk); frm_start = 1;                // R8 start while busy
        @(negedge clk); frm_start = 1;
        @(negedge clk); frm_start = 0; ovf_clr = 1;   // R9 clear
        @(negedge clk); ovf_clr = 0; frm_start = 1;
        @(negedge clk); frm_start = 0; ovf_clr = 0;
        @(negedge clk); frm_done = 1; frm_len = 2;
        @(negedge clk); frm_done = 0;
        service(8);
        peek_all();
        finish_run();
    end
endmodule